// File: doc/BRIEF.md
# Capture/Compare Event Timer

This block is a free-running event timer that a processor reaches through a small byte-wide register bus. A 16-bit counter advances on every cycle in which the tick enable input is high. An input capture channel watches an asynchronous pin. It resynchronises the pin, detects an edge of a programmable polarity, and stores the counter value at that moment. An output compare channel watches for the counter to reach a programmed value. When it does, it drives a pin to a programmable level.

Three conditions are recorded in a status register: capture, compare and counter wrap. Each flag is cleared by a two-step handshake. Software first reads the status register and then touches the data register that belongs to that flag. A flag that rises after the status read survives the second step, so no event is lost between the two steps. Each flag has its own enable bit, and the block presents a single interrupt request line that combines the three.

The register map is fixed, with one 3-bit address per register: 0 control, 1 status, 2 capture high, 3 capture low, 4 compare high, 5 compare low, 6 counter high, 7 counter low. Read data is combinational from the address while the read strobe is high. Register side effects take place on the clock edge at which the strobe is high.

Top module: `cc_timer`

## Requirements
- R1: After reset the control, status, counter and capture registers read 0x00. Both compare bytes read 0xFF. `cmp_out` and `irq` are low.
- R2: The counter increments by one on each rising clock edge at which `tick_en` is high. It holds its value otherwise, and wraps from 0xFFFF to 0x0000. Address 6 reads its high byte and address 7 its low byte.
- R3: Control bit 1 selects the capture polarity: 1 means rising edge, 0 means falling edge. `cap_in` passes through a two-flop synchronizer. An edge of the selected polarity copies the counter into the capture register, which is read at address 2 (high byte) and address 3 (low byte). An edge of the other polarity changes nothing.
- R4: A tick that brings the counter equal to the compare register sets the compare flag. On the same edge it copies control bit 0 to `cmp_out`: a 1 drives the pin high and a 0 drives it low. The compare register is written at address 4 (high byte) and address 5 (low byte).
- R5: The status register at address 1 holds the capture flag in bit 7, the compare flag in bit 6 and the wrap flag in bit 5. Bits 4 to 0 always read 0.
- R6: A flag clears only when a status read is followed by its own second step. The second step is a read of address 3 for capture, a write of address 5 for compare, and a read of address 7 for wrap. The same second step without a status read before it leaves the flag set.
- R7: The second step clears a flag only if that flag was already set at the preceding status read. A flag that sets after that read stays set.
- R8: The wrap flag sets on the tick that takes the counter from 0xFFFF to 0x0000.
- R9: Control bit 7 enables the capture interrupt, bit 6 the compare interrupt and bit 5 the wrap interrupt. `irq` is high whenever any flag is set together with its enable bit.
- R10: While control bit 5 is 0, a counter wrap sets its flag but leaves `irq` low.
- R11: Control bits 4 to 2 read 0. Writes to addresses 1, 2, 3, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Counter advance enable, one count per cycle while high |
| cap_in | input | 1 | Asynchronous capture pin |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench reads a data register without a status read first. A design that clears on the second step alone would then show the capture or compare flag missing. It also raises a capture after the status read and before the low-byte read. A design that clears on that read instead of from the armed snapshot would lose the event. It drives edges of the unselected polarity in both modes, where a wrong polarity decode would record a capture. Finally, it runs the counter through a full wrap with the wrap interrupt disabled and then enabled. A design that gated the flag rather than the request, or set the flag on the wrong tick, shows up there.

// File: rtl/cct_pkg.sv
// Shared types and constants for the capture/compare event timer.
// Assumes a byte-wide bus with eight register addresses.
package cct_pkg;

    // Register addresses; the map is fixed by the software view.
    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_CAPH = 3'd2,
        A_CAPL = 3'd3,
        A_CMPH = 3'd4,
        A_CMPL = 3'd5,
        A_CNTH = 3'd6,
        A_CNTL = 3'd7
    } reg_addr_e;

    // Control register layout, most significant field first.
    typedef struct packed {
        logic       cap_ie;
        logic       cmp_ie;
        logic       wrap_ie;
        logic [2:0] rsv;
        logic       cap_rise;
        logic       cmp_lvl;
    } ctrl_t;

    // Writable control bits; reserved bits stay zero.
    localparam logic [7:0] CTRL_MASK = 8'hE3;

    // Flag indices into the per-flag vectors.
    localparam int NFLAG  = 3;
    localparam int F_CAP  = 0;
    localparam int F_CMP  = 1;
    localparam int F_WRAP = 2;

endpackage

// File: rtl/cct_sync_edge.sv
// Synchronizes an asynchronous pin through a flop chain and reports one
// edge of a selectable polarity as a single-cycle event.
// Assumes STAGES >= 2 and that the pin is low while reset is applied.
module cct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    input  logic rise_sel_i,
    output logic evt_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise, fall;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_i};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // Decode both edges and pick the selected one.
    always_comb begin
        rise  = sync_q[LAST] & ~prev_q;
        fall  = ~sync_q[LAST] & prev_q;
        evt_o = rise_sel_i ? rise : fall;
    end

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R3
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/cct_counter.sv
// Free-running up counter that advances on each enabled tick and flags
// the tick that wraps it from all ones back to zero.
// Assumes tick_i is synchronous to clk.
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    // Advance on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    // Expose the count and flag the wrapping tick.
    always_comb begin
        cnt_o  = cnt_q;
        wrap_o = tick_i & (&cnt_q);
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_o == $past(cnt_o) + 1'b1);
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));
    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> cnt_o == '0);

endmodule

// File: rtl/cct_flag.sv
// One status flag with the two-step clear handshake. A status read
// snapshots the flag into an arm bit; the later second step clears the
// flag only if armed. A new set always wins over a clear.
// Assumes the status read and second step never share a cycle.
module cct_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q, arm_q;

    // Hold the flag: set has priority, armed second step clears.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (set_i)          flag_q <= 1'b1;
        else if (clr_i && arm_q) flag_q <= 1'b0;
    end

    // Arm from the flag at each status read, disarm on the second step.
    always_ff @(posedge clk) begin
        if (!rst_n)         arm_q <= 1'b0;
        else if (clr_i)     arm_q <= 1'b0;
        else if (stat_rd_i) arm_q <= flag_q;
    end

    assign flag_o = flag_q;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R6
    unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !arm_q && flag_o) |=> flag_o);
    // R7
    arm_from_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !flag_o) |=> !arm_q);

endmodule

// File: rtl/cc_timer.sv
// Capture/compare event timer top. Holds the register file and the
// compare and capture datapaths, instantiates the counter, the pin
// synchronizer and one flag cell per event, and forms the interrupt.
// Assumes 9 <= CNT_W <= 16 so each timer value spans two bytes.
module cc_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       cap_in,
    input  logic [2:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       cmp_out,
    output logic       irq
);
    import cct_pkg::*;

    localparam int HI_W = CNT_W - 8;

    reg_addr_e          addr;
    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   cnt, cnt_nxt, cap_q, cmp_q;
    logic               wrap, cap_evt, cmp_hit, stat_rd, cmp_out_q;
    logic [NFLAG-1:0]   f_set, f_clr, f_q, f_ie;

    assign addr = reg_addr_e'(bus_addr);

    cct_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_en),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_i    (cap_in),
        .rise_sel_i (ctrl_q.cap_rise),
        .evt_o      (cap_evt)
    );

    // Decode the compare event and the per-flag strobes.
    always_comb begin
        cnt_nxt        = cnt + 1'b1;
        cmp_hit        = tick_en && (cnt_nxt == cmp_q);
        stat_rd        = bus_rd && (addr == A_STAT);
        f_set[F_CAP]   = cap_evt;
        f_set[F_CMP]   = cmp_hit;
        f_set[F_WRAP]  = wrap;
        f_clr[F_CAP]   = bus_rd && (addr == A_CAPL);
        f_clr[F_CMP]   = bus_wr && (addr == A_CMPL);
        f_clr[F_WRAP]  = bus_rd && (addr == A_CNTL);
        f_ie[F_CAP]    = ctrl_q.cap_ie;
        f_ie[F_CMP]    = ctrl_q.cmp_ie;
        f_ie[F_WRAP]   = ctrl_q.wrap_ie;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        cct_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (f_set[i]),
            .stat_rd_i (stat_rd),
            .clr_i     (f_clr[i]),
            .flag_o    (f_q[i])
        );
    end

    // Control register write, reserved bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (bus_wr && addr == A_CTRL)    ctrl_q <= ctrl_t'(bus_wdata & CTRL_MASK);
    end

    // Compare register byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (bus_wr && addr == A_CMPH) begin
            cmp_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
        end else if (bus_wr && addr == A_CMPL) begin
            cmp_q[7:0] <= bus_wdata;
        end
    end

    // Capture register loads the counter on a selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= cnt;
    end

    // Compare pin takes the programmed level on each match.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_out_q <= 1'b0;
        else if (cmp_hit) cmp_out_q <= ctrl_q.cmp_lvl;
    end

    // Read data multiplexer.
    always_comb begin
        unique case (addr)
            A_CTRL:  bus_rdata = 8'(ctrl_q);
            A_STAT:  bus_rdata = {f_q[F_CAP], f_q[F_CMP], f_q[F_WRAP], 5'b0};
            A_CAPH:  bus_rdata = 8'(cap_q >> 8);
            A_CAPL:  bus_rdata = cap_q[7:0];
            A_CMPH:  bus_rdata = 8'(cmp_q >> 8);
            A_CMPL:  bus_rdata = cmp_q[7:0];
            A_CNTH:  bus_rdata = 8'(cnt >> 8);
            A_CNTL:  bus_rdata = cnt[7:0];
            default: bus_rdata = 8'h00;
        endcase
    end

    // Output pins.
    always_comb begin
        cmp_out = cmp_out_q;
        irq     = |(f_q & f_ie);
    end

    // R4
    cmp_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> cmp_out == $past(ctrl_q.cmp_lvl));
    // R4
    cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> f_q[F_CMP]);
    // R5
    stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> bus_rdata[4:0] == 5'b0);
    // R8
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> f_q[F_WRAP]);
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_ie == '0) |-> !irq);
    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_q));

endmodule

// File: tb/cc_timer_tb.sv
`timescale 1ns/1ps
module cc_timer_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n, tick_en, cap_in, bus_rd, bus_wr;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       cmp_out, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       mon_ev;

    always #(CLK_P/2) clk = ~clk;

    cc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_in(cap_in),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_out(cmp_out), .irq(irq)
    );

    // Monitor: pops the expected byte for each read and compares.
    always begin
        @(mon_ev);
        if (exp_q.size() != 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: read got %02h expected %02h", t, bus_rdata, e);
            end
        end
    end

    // Driver: one read cycle; expected value goes to the scoreboard.
    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        #(CLK_P/4);
        ->mon_ev;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin(input logic got, input logic e, input string t);
        checks++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s: pin got %0b expected %0b", t, got, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; cap_in = 1'b0;
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, 8'h00, "R1 ctrl");
        rd(3'd1, 8'h00, "R1 status");
        rd(3'd7, 8'h00, "R1 cnt lo");
        rd(3'd6, 8'h00, "R1 cnt hi");
        rd(3'd5, 8'hFF, "R1 cmp lo");
        rd(3'd4, 8'hFF, "R1 cmp hi");
        rd(3'd3, 8'h00, "R1 cap lo");
        pin(cmp_out, 1'b0, "R1 cmp_out");
        pin(irq, 1'b0, "R1 irq");

        // R2 counting: 300 ticks -> 0x012C
        ticks(300);
        rd(3'd7, 8'h2C, "R2 cnt lo");
        rd(3'd6, 8'h01, "R2 cnt hi");
        idle(5);
        rd(3'd7, 8'h2C, "R2 hold without tick");

        // R11 writes to read-only addresses ignored
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'h00, "R11 status write ignored");
        wr(3'd7, 8'h00);
        rd(3'd7, 8'h2C, "R11 counter write ignored");
        wr(3'd0, 8'hFF);
        rd(3'd0, 8'hE3, "R11 reserved ctrl bits");

        // R3 rising capture
        wr(3'd0, 8'h02);
        cap_in = 1'b1; idle(4);
        rd(3'd3, 8'h2C, "R3 cap lo rising");
        rd(3'd2, 8'h01, "R3 cap hi rising");
        rd(3'd1, 8'h80, "R6 no clear without status read");
        rd(3'd3, 8'h2C, "R6 second step");
        rd(3'd1, 8'h00, "R6 capture flag cleared");

        // R3 falling edge ignored while rising selected
        ticks(20);                       // 0x0140
        cap_in = 1'b0; idle(4);
        rd(3'd1, 8'h00, "R3 falling ignored flag");
        rd(3'd3, 8'h2C, "R3 falling ignored value");

        // R3 falling mode
        wr(3'd0, 8'h00);
        cap_in = 1'b1; idle(4);
        rd(3'd1, 8'h00, "R3 rising ignored in falling mode");
        ticks(16);                       // 0x0150
        cap_in = 1'b0; idle(4);
        rd(3'd1, 8'h80, "R3 falling capture flag");
        rd(3'd3, 8'h50, "R3 falling capture value");
        rd(3'd1, 8'h00, "R6 cleared after handshake");

        // R7 flag set between the two steps survives
        cap_in = 1'b1; idle(4);
        ticks(1);                        // 0x0151
        cap_in = 1'b0; idle(4);
        rd(3'd3, 8'h51, "R7 second step after late set");
        rd(3'd1, 8'h80, "R7 flag survives");
        rd(3'd3, 8'h51, "R7 clear");
        rd(3'd1, 8'h00, "R7 cleared");

        // R9 capture interrupt
        wr(3'd0, 8'h80);
        pin(irq, 1'b0, "R9 no flag no irq");
        cap_in = 1'b1; idle(4);
        cap_in = 1'b0; idle(4);
        pin(irq, 1'b1, "R9 capture irq");
        rd(3'd1, 8'h80, "R9 status");
        rd(3'd3, 8'h51, "R9 clear");
        pin(irq, 1'b0, "R9 irq dropped");

        // R4 compare high level
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h56);
        wr(3'd0, 8'h41);
        ticks(4);                        // 0x0155
        pin(cmp_out, 1'b0, "R4 before match");
        rd(3'd1, 8'h00, "R4 no flag before match");
        ticks(1);                        // 0x0156
        pin(cmp_out, 1'b1, "R4 high on match");
        pin(irq, 1'b1, "R9 compare irq");
        rd(3'd1, 8'h40, "R5 compare bit");
        wr(3'd5, 8'h5A);
        rd(3'd1, 8'h00, "R6 compare cleared by write");
        pin(irq, 1'b0, "R9 compare irq dropped");

        // R4 compare low level; R6 write without status read
        wr(3'd0, 8'h00);
        ticks(4);                        // 0x015A
        pin(cmp_out, 1'b0, "R4 low on match");
        wr(3'd5, 8'h5A);
        rd(3'd1, 8'h40, "R6 compare kept without status read");
        wr(3'd5, 8'h5A);
        rd(3'd1, 8'h00, "R6 compare cleared");

        // R8/R10 wrap
        ticks(65536 - 346);
        rd(3'd1, 8'h20, "R8 wrap flag");
        pin(irq, 1'b0, "R10 wrap irq masked");
        wr(3'd0, 8'h20);
        pin(irq, 1'b1, "R9 wrap irq enabled");
        rd(3'd6, 8'h00, "R8 cnt hi after wrap");
        rd(3'd7, 8'h00, "R8 cnt lo clears flag");
        rd(3'd1, 8'h00, "R6 wrap cleared");
        pin(irq, 1'b0, "R9 wrap irq dropped");

        idle(2);
        finish_run();
    end
endmodule